// File: doc/BRIEF.md
# Synchronous Memory Controller with Read-Modify-Write Byte Stores

This block sits between a small 16-bit soft processor and two memories. One is an on-chip boot ROM of 256 sixteen-bit words, read through a block-RAM port. The other is an external 16-bit asynchronous SRAM bank. The top bit of each request address picks the target. ROM reads complete with no wait state. Every SRAM access adds one wait state, so that the external timing holds at higher clock rates.

The SRAM has no byte-write-enable pins. A byte store is therefore done as a read-modify-write. The controller reads the full word, replaces one byte lane, and writes the whole word back.

The processor holds its request until `cpu_ready` is high. While a multi-cycle access is in progress the controller takes no new request. Its state is registered on a single clock. The ROM's ready and read data are decoded from that state and the request within the cycle, which gives the ROM its zero-wait path.

Top module: `sync_memctl`

## Requirements
- R1: Address bit 15 selects the target: 0 is the ROM, 1 is the SRAM. In the ROM region only bits [8:1] form the ROM word index, so bits [14:9] mirror the 256-word ROM. In the SRAM region bits [14:1] form the SRAM word address.
- R2: A ROM read raises `cpu_ready` in the same cycle as the request, with `cpu_rdata` equal to the word at `rom_addr`.
- R3: A write to the ROM region is dropped. `cpu_ready` still rises in the request cycle, and no SRAM strobe (chip, output or write enable) goes low as a result.
- R4: An SRAM read, word or byte, raises `cpu_ready` in the second cycle and returns the whole 16-bit word. Bit 0 of the address does not affect it.
- R5: An SRAM word write raises `cpu_ready` in the second cycle and stores all 16 bits of `cpu_wdata`. Bit 0 of the address is ignored.
- R6: An SRAM byte store raises `cpu_ready` in the fourth cycle, after a read, a gap and a write-back. The byte comes from `cpu_wdata[7:0]`. Address bit 0 = 0 replaces bits [7:0] and bit 0 = 1 replaces bits [15:8]. The other lane keeps its old value.
- R7: `sram_we_n` is never low in a cycle in which `sram_addr` differs from the previous cycle. `sram_dout_en` is high only while `sram_we_n` is low, and never while `sram_oe_n` is low.
- R8: The address, data and kind of access are captured when an SRAM request is accepted. Changes on the processor inputs during the rest of that access have no effect.
- R9: After a synchronous reset (`rst_n` low at a clock edge), `sram_ce_n`, `sram_oe_n` and `sram_we_n` are high and `sram_dout_en` is low. With no request, `cpu_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_byte | input | 1 | 1 = byte access |
| cpu_addr | input | 16 | Byte address; bit 15 picks the target |
| cpu_wdata | input | 16 | Write data; a byte store uses [7:0] |
| cpu_rdata | output | 16 | Read data, valid while ready is high |
| cpu_ready | output | 1 | Access completes this cycle |
| rom_addr | output | 8 | Boot ROM word index |
| rom_data | input | 16 | Boot ROM word |
| sram_addr | output | 14 | SRAM word address |
| sram_din | input | 16 | Data read from the SRAM |
| sram_dout | output | 16 | Data written to the SRAM |
| sram_dout_en | output | 1 | Drive enable for the SRAM data bus |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The embedded assertions check the following on every cycle:
- the address stays steady under an active write strobe;
- the data bus is never driven while the SRAM is driving it;
- each SRAM access carries exactly one wait state;
- the read, gap and write-back phases of a byte store come in that order;
- the SRAM address holds during a busy access;
- a ROM request never starts an SRAM cycle.

Other behaviour can only be shown by the bench scenarios against its SRAM and ROM models:
- the merged byte values;
- the lane chosen by address bit 0;
- the ROM mirror;
- the exact cycle in which ready rises;
- that inputs changed during an access are ignored.

// File: rtl/smc_pkg.sv
// Package: shared state encoding and default sizes for the memory controller.
// Assumes two byte lanes per data word.
package smc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD      = 3'd1,
        ST_WR      = 3'd2,
        ST_RMW_RD  = 3'd3,
        ST_RMW_GAP = 3'd4,
        ST_RMW_WR  = 3'd5
    } smc_state_e;

    localparam int SMC_ADDR_W = 16;
    localparam int SMC_DATA_W = 16;
    localparam int SMC_ROM_AW = 8;
endpackage

// File: rtl/smc_decode.sv
// Address decoder: splits a byte address (bit 0 removed) into the target
// select, the ROM word index and the SRAM word address.
// Assumes ROM_AW <= ADDR_W - 2. The upper ROM-region bits are left out,
// which mirrors the ROM.
module smc_decode #(
    parameter int ADDR_W = 16,
    parameter int ROM_AW = 8,
    localparam int SRAM_AW = ADDR_W - 2
) (
    input  logic [ADDR_W-1:1]  addr_hi,
    output logic               ext_sel,
    output logic [ROM_AW-1:0]  rom_word,
    output logic [SRAM_AW-1:0] sram_word
);
    // Target select and index extraction.
    always_comb begin
        ext_sel   = addr_hi[ADDR_W-1];
        sram_word = addr_hi[ADDR_W-2:1];
        rom_word  = sram_word[ROM_AW-1:0];
    end
endmodule

// File: rtl/smc_fsm.sv
// Access sequencer: walks the SRAM cycles (word read, word write, and the
// read / gap / write-back of a byte store) and drives the registered SRAM
// strobes. Assumes the CPU holds its request until ready.
module smc_fsm
    import smc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       we,
    input  logic       bsel,
    input  logic       ext_sel,
    output smc_state_e st,
    output logic       accept,
    output logic       ext_ready,
    output logic       ce_n,
    output logic       oe_n,
    output logic       we_n,
    output logic       dout_en
);
    smc_state_e nxt;

    // Accept an SRAM request only while idle.
    always_comb accept = (st == ST_IDLE) && req && ext_sel;

    // Next-state decode.
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:    if (accept) nxt = !we ? ST_RD : (bsel ? ST_RMW_RD : ST_WR);
            ST_RD:      nxt = ST_IDLE;
            ST_WR:      nxt = ST_IDLE;
            ST_RMW_RD:  nxt = ST_RMW_GAP;
            ST_RMW_GAP: nxt = ST_RMW_WR;
            ST_RMW_WR:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // State and strobe registers, strobes decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            ce_n    <= 1'b1;
            oe_n    <= 1'b1;
            we_n    <= 1'b1;
            dout_en <= 1'b0;
        end else begin
            st      <= nxt;
            ce_n    <= (nxt == ST_IDLE);
            oe_n    <= !((nxt == ST_RD) || (nxt == ST_RMW_RD));
            we_n    <= !((nxt == ST_WR) || (nxt == ST_RMW_WR));
            dout_en <= (nxt == ST_WR) || (nxt == ST_RMW_WR);
        end
    end

    // Completion of an SRAM access.
    always_comb ext_ready = (st == ST_RD) || (st == ST_WR) || (st == ST_RMW_WR);

    AST_ONE_WAIT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RD) || (st == ST_WR)) |-> $past(st) == ST_IDLE); // R4
    AST_RMW_GAP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RMW_GAP) |-> $past(st) == ST_RMW_RD); // R6
    AST_RMW_WB_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RMW_WR) |-> $past(st) == ST_RMW_GAP); // R6
endmodule

// File: rtl/smc_datapath.sv
// Datapath: captures the address and data when a request is accepted,
// presents the SRAM address (the live CPU address while idle, the held
// address while busy), and merges the store byte into the word read back.
// Assumes two byte lanes per word.
module smc_datapath
    import smc_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SRAM_AW = 14,
    localparam int LANE_W = DATA_W / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  smc_state_e         st,
    input  logic               accept,
    input  logic               lane_in,
    input  logic [SRAM_AW-1:0] word_in,
    input  logic [DATA_W-1:0]  wdata_in,
    input  logic [DATA_W-1:0]  sram_din,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [DATA_W-1:0]  sram_dout
);
    logic [SRAM_AW-1:0] hold_word;
    logic               hold_lane;
    logic [DATA_W-1:0]  hold_data;
    logic [DATA_W-1:0]  merged;

    // Replace the selected lane of the word read back.
    always_comb begin
        if (hold_lane) merged = {hold_data[LANE_W-1:0], sram_din[LANE_W-1:0]};
        else           merged = {sram_din[DATA_W-1:LANE_W], hold_data[LANE_W-1:0]};
    end

    // Capture on accept; fold in the read word during the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_word <= '0;
            hold_lane <= 1'b0;
            hold_data <= '0;
        end else if (accept) begin
            hold_word <= word_in;
            hold_lane <= lane_in;
            hold_data <= wdata_in;
        end else if (st == ST_RMW_RD) begin
            hold_data <= merged;
        end
    end

    // Address source: live while idle, held while busy.
    always_comb sram_addr = (st == ST_IDLE) ? word_in : hold_word;
    always_comb sram_dout = hold_data;

    AST_BUSY_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(sram_addr)); // R8
endmodule

// File: rtl/sync_memctl.sv
// Top: a memory controller for a 16-bit CPU. It serves a 256-word boot ROM
// with zero wait states and an external asynchronous 16-bit SRAM with one
// wait state, and turns byte stores into a read-modify-write. Assumes the
// ROM read port returns data in the same cycle as rom_addr and that the CPU
// holds its request until ready.
module sync_memctl
    import smc_pkg::*;
#(
    parameter int ADDR_W = SMC_ADDR_W,
    parameter int DATA_W = SMC_DATA_W,
    parameter int ROM_AW = SMC_ROM_AW,
    localparam int SRAM_AW = ADDR_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic               cpu_byte,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_ready,
    output logic [ROM_AW-1:0]  rom_addr,
    input  logic [DATA_W-1:0]  rom_data,
    output logic [SRAM_AW-1:0] sram_addr,
    input  logic [DATA_W-1:0]  sram_din,
    output logic [DATA_W-1:0]  sram_dout,
    output logic               sram_dout_en,
    output logic               sram_ce_n,
    output logic               sram_oe_n,
    output logic               sram_we_n
);
    smc_state_e         st;
    logic               ext_sel;
    logic               accept;
    logic               ext_ready;
    logic [SRAM_AW-1:0] word_addr;

    smc_decode #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) u_dec (
        .addr_hi  (cpu_addr[ADDR_W-1:1]),
        .ext_sel  (ext_sel),
        .rom_word (rom_addr),
        .sram_word(word_addr)
    );

    smc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (cpu_req),
        .we       (cpu_we),
        .bsel     (cpu_byte),
        .ext_sel  (ext_sel),
        .st       (st),
        .accept   (accept),
        .ext_ready(ext_ready),
        .ce_n     (sram_ce_n),
        .oe_n     (sram_oe_n),
        .we_n     (sram_we_n),
        .dout_en  (sram_dout_en)
    );

    smc_datapath #(.DATA_W(DATA_W), .SRAM_AW(SRAM_AW)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .st       (st),
        .accept   (accept),
        .lane_in  (cpu_addr[0]),
        .word_in  (word_addr),
        .wdata_in (cpu_wdata),
        .sram_din (sram_din),
        .sram_addr(sram_addr),
        .sram_dout(sram_dout)
    );

    // Ready: zero-wait ROM hit while idle, or completion of an SRAM access.
    always_comb cpu_ready = ((st == ST_IDLE) && cpu_req && !ext_sel) || ext_ready;

    // Read data source: the SRAM during a word read, else the ROM.
    always_comb cpu_rdata = (st == ST_RD) ? sram_din : rom_data;

    AST_WE_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> $stable(sram_addr)); // R7
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> !sram_dout_en); // R7
    AST_DRIVE_ONLY_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dout_en |-> !sram_we_n && !sram_ce_n); // R7
    AST_ROM_NO_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cpu_req && !cpu_addr[ADDR_W-1]) |=> sram_ce_n); // R3
endmodule

// File: tb/sync_memctl_test.sv
// Bench: a vector table of accesses with expected data and cycle counts,
// then directed tests for reset, ignored ROM writes, strobe timing and
// inputs changed in mid-access.
module sync_memctl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we, cpu_byte;
    logic [15:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_ready;
    logic [7:0]  rom_addr;
    logic [15:0] rom_data;
    logic [13:0] sram_addr;
    logic [15:0] sram_din, sram_dout;
    logic        sram_dout_en, sram_ce_n, sram_oe_n, sram_we_n;

    int checks = 0;
    int fails  = 0;
    int we_pulses = 0;
    int strobe_faults = 0;
    logic [13:0] prev_addr;
    logic [15:0] mem [0:255];

    always #2 clk = ~clk;

    sync_memctl uut (.*);

    // ROM model: word derived from its index.
    always_comb rom_data = {~rom_addr, rom_addr ^ 8'hA5};

    // SRAM model: asynchronous read, write at the clock edge while strobed.
    always_comb sram_din = (!sram_ce_n && !sram_oe_n) ? mem[sram_addr[7:0]] : 16'hDEAD;
    always @(posedge clk) begin
        if (!sram_ce_n && !sram_we_n && sram_dout_en) mem[sram_addr[7:0]] <= sram_dout;
        if (!sram_we_n) we_pulses <= we_pulses + 1;
        prev_addr <= sram_addr;
    end
    // Strobe rule monitor (R7), sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (!sram_we_n && sram_addr !== prev_addr) strobe_faults++;
            if (sram_dout_en && (sram_we_n || !sram_oe_n)) strobe_faults++;
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // One access: drive at negedge, wait for ready, optionally change inputs
    // after the first busy cycle.
    task automatic access(input logic we, input logic bs, input logic [15:0] a,
                          input logic [15:0] wd, input logic perturb,
                          output logic [15:0] rd, output int cyc);
        cpu_req = 1'b1; cpu_we = we; cpu_byte = bs; cpu_addr = a; cpu_wdata = wd;
        cyc = 1;
        rd = 16'h0;
        forever begin
            #1;
            if (cpu_ready) begin
                rd = cpu_rdata;
                break;
            end
            if (cyc > 20) begin
                fails++;
                $display("FAIL watchdog access actual=hung expected=ready");
                break;
            end
            @(negedge clk);
            cyc++;
            if (perturb && cyc == 2) begin
                cpu_addr = 16'h8050; cpu_wdata = 16'h0099; cpu_we = 1'b0; cpu_byte = 1'b0;
            end
        end
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic        bs;
        logic [15:0] addr;
        logic [15:0] wd;
        logic [2:0]  cyc;
        logic [15:0] exp;
        logic        chkd;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 16'h0004, 16'h0000, 3'd1, 16'hFDA7, 1'b1, 4'd2}, // R2 ROM read
        '{1'b0, 1'b0, 16'h7E04, 16'h0000, 3'd1, 16'hFDA7, 1'b1, 4'd1}, // R1 mirror
        '{1'b0, 1'b0, 16'h01FE, 16'h0000, 3'd1, 16'h005A, 1'b1, 4'd2}, // R2 top index
        '{1'b0, 1'b0, 16'h8010, 16'h0000, 3'd2, 16'h08F7, 1'b1, 4'd4}, // R4 word read
        '{1'b0, 1'b0, 16'h8011, 16'h0000, 3'd2, 16'h08F7, 1'b1, 4'd4}, // R4 bit 0 ignored
        '{1'b1, 1'b0, 16'h8021, 16'h1234, 3'd2, 16'h0000, 1'b0, 4'd5}, // R5 word write
        '{1'b0, 1'b0, 16'h8020, 16'h0000, 3'd2, 16'h1234, 1'b1, 4'd5}, // R5 read back
        '{1'b1, 1'b1, 16'h8030, 16'hAB55, 3'd4, 16'h0000, 1'b0, 4'd6}, // R6 lane 0
        '{1'b0, 1'b0, 16'h8030, 16'h0000, 3'd2, 16'h1855, 1'b1, 4'd6}, // R6 merged
        '{1'b1, 1'b1, 16'h8031, 16'h00C3, 3'd4, 16'h0000, 1'b0, 4'd6}, // R6 lane 1
        '{1'b0, 1'b0, 16'h8031, 16'h0000, 3'd2, 16'hC355, 1'b1, 4'd6}, // R6 merged
        '{1'b1, 1'b0, 16'h0004, 16'hFFFF, 3'd1, 16'h0000, 1'b0, 4'd3}, // R3 ROM write
        '{1'b0, 1'b0, 16'h0004, 16'h0000, 3'd1, 16'hFDA7, 1'b1, 4'd3}, // R3 read after
        '{1'b0, 1'b1, 16'h8011, 16'h0000, 3'd2, 16'h08F7, 1'b1, 4'd4}  // R4 byte read
    };

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int          cyc;
        int          w0;
        for (int i = 0; i < 256; i++) mem[i] = {8'(i), ~8'(i)};
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_byte = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        chk("R9 ready", cpu_ready, 0);
        chk("R9 strobes", {sram_ce_n, sram_oe_n, sram_we_n, sram_dout_en}, 4'b1110);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            w0 = we_pulses;
            access(VEC[i].we, VEC[i].bs, VEC[i].addr, VEC[i].wd, 1'b0, rd, cyc);
            chk($sformatf("R%0d cycles vec %0d", VEC[i].rq, i), cyc, VEC[i].cyc);
            if (VEC[i].chkd) chk($sformatf("R%0d data vec %0d", VEC[i].rq, i), rd, VEC[i].exp);
            if (i == 11) begin
                @(negedge clk);
                chk("R3 no write strobe", we_pulses - w0, 0);
            end
        end

        // R8: byte store with inputs changed in mid-access.
        access(1'b1, 1'b1, 16'h8041, 16'h0077, 1'b1, rd, cyc);
        chk("R8 cycles", cyc, 4);
        access(1'b0, 1'b0, 16'h8040, 16'h0000, 1'b0, rd, cyc);
        chk("R8 target written", rd, 16'h77DF);
        access(1'b0, 1'b0, 16'h8050, 16'h0000, 1'b0, rd, cyc);
        chk("R8 other word untouched", rd, 16'h28D7);

        // R6 back-to-back byte stores to both lanes of one word.
        access(1'b1, 1'b1, 16'h8060, 16'h0011, 1'b0, rd, cyc);
        access(1'b1, 1'b1, 16'h8061, 16'h0022, 1'b0, rd, cyc);
        access(1'b0, 1'b0, 16'h8060, 16'h0000, 1'b0, rd, cyc);
        chk("R6 both lanes", rd, 16'h2211);

        // R9 idle after traffic.
        @(negedge clk); #1;
        chk("R9 idle strobes", {sram_ce_n, sram_oe_n, sram_we_n, sram_dout_en}, 4'b1110);
        chk("R7 strobe faults", strobe_faults, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule